// File: doc/BRIEF.md
# Sparse-Block Scan Data Decompressor

This block expands a serial compressed test stream into fixed-width blocks of scan data. Every block of `BLK_W` bits is introduced by a short prefix code, and that code names one of four kinds of block. The shortest code gives a block of all zeros. The next code gives a block of all ones. A third code gives a sparse block, which is sent as a bit count followed by the position of each 1. The last code gives an uncoded block, which is sent as its raw bits.

Compressed bits enter one per cycle under a valid/ready handshake. A finished block is presented on a parallel output with a valid strobe and is held until the consumer takes it. While a finished block waits, the decoder accepts no further compressed bits. It resumes decoding the next prefix once the block has been handed over.

Top module: `sparse_blk_decomp`

## Requirements
- R1: While `rst_n` is low, and after it is released, `blk_valid` is low and `in_ready` is high. Any partly decoded block is discarded, and the next accepted bit is treated as the first bit of a prefix.
- R2: The single prefix bit 0 produces a block whose bits are all 0.
- R3: The prefix bits 1 then 0 produce a block whose bits are all 1.
- R4: The prefix bits 1, 1, 0 start a sparse block. It continues with a count field of `$clog2(BLK_W+1)` bits, then that many location fields of `$clog2(BLK_W)` bits each. Every field arrives most significant bit first. The block has a 1 at each listed location and 0 everywhere else, and `blk_data[i]` is scan position i.
- R5: A sparse block with a count of 0 produces an all-zero block, and the very next accepted bit is read as a prefix.
- R6: A location that is listed more than once in a sparse block gives the same block as listing it once.
- R7: The prefix bits 1, 1, 1 are followed by exactly `BLK_W` raw bits. The first raw bit received lands in `blk_data[0]` and the last lands in `blk_data[BLK_W-1]`.
- R8: `blk_valid` rises in the cycle after the bit that completes a block is accepted. `in_ready` is low whenever `blk_valid` is high.
- R9: While `blk_valid` is high and `blk_ready` is low, `blk_valid` and `blk_data` stay unchanged. In the cycle after a cycle with both high, `blk_valid` is low and `in_ready` is high.
- R10: A bit is consumed only in a cycle where `in_valid` and `in_ready` are both high, so idle cycles between input bits do not change the decoded blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A compressed bit is offered |
| in_bit | input | 1 | Compressed stream bit |
| in_ready | output | 1 | Decoder can accept a bit this cycle |
| blk_valid | output | 1 | A rebuilt block is presented |
| blk_ready | input | 1 | Consumer takes the presented block |
| blk_data | output | BLK_W | Rebuilt block, bit i is scan position i |

## Verification
The bench builds the block with its default width of 8. This gives 3-bit location fields that reach every position of a block, and a 4-bit count field that can name all 8 positions. The full-block sparse case, a count of zero and repeated positions therefore all occur in a short stream. The power-of-two width means no location is ever out of range. Backpressure with periodic stalls, idle gaps in the input, and a reset in the middle of a raw block are all exercised against the same expected-block queue.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // decoder phases
  typedef enum logic [2:0] {
    ST_PFX,
    ST_CNT,
    ST_LOC,
    ST_RAW,
    ST_OUT
  } sbd_state_e;

  // operations applied to the block register
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_ZERO,
    OP_ONES,
    OP_CLR,
    OP_SET,
    OP_RAW
  } sbd_op_e;

endpackage

// File: rtl/sbd_field.sv
module sbd_field #(
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             in_bit,
  output logic [FLD_W-1:0] fld_nx
);

  logic [FLD_W-2:0] fld_q;
  logic [FLD_W-2:0] fld_d;

  assign fld_nx = {fld_q, in_bit};

  always_comb begin
    fld_d = fld_q;
    if (shift_en) fld_d = fld_nx[FLD_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (shift_en) begin
      fld_q <= fld_d;
    end
  end

endmodule

// File: rtl/sbd_blk_reg.sv
module sbd_blk_reg
  import sbd_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int LOC_W = $clog2(BLK_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sbd_op_e          op,
  input  logic [LOC_W-1:0] loc,
  input  logic [LOC_W-1:0] idx,
  input  logic             in_bit,
  output logic [BLK_W-1:0] blk_q
);

  logic [BLK_W-1:0] blk_d;
  logic             blk_en;

  assign blk_en = (op != OP_HOLD);

  for (genvar g = 0; g < BLK_W; g++) begin : g_bit
    always_comb begin
      unique case (op)
        OP_ZERO, OP_CLR: blk_d[g] = 1'b0;
        OP_ONES:         blk_d[g] = 1'b1;
        OP_SET:          blk_d[g] = (loc == LOC_W'(g)) ? 1'b1 : blk_q[g];
        OP_RAW:          blk_d[g] = (idx == LOC_W'(g)) ? in_bit : blk_q[g];
        default:         blk_d[g] = blk_q[g];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_d;
    end
  end

endmodule

// File: rtl/sbd_fsm.sv
module sbd_fsm
  import sbd_pkg::*;
#(
  parameter int BLK_W = 8,
  parameter int LOC_W = $clog2(BLK_W),
  parameter int CNT_W = $clog2(BLK_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             blk_ready,
  input  logic [CNT_W-1:0] fld_nx,
  output logic             in_ready,
  output logic             blk_valid,
  output logic             fld_shift,
  output sbd_op_e          op,
  output logic [LOC_W-1:0] idx
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_W - 1);
  localparam logic [CNT_W-1:0] LOC_LAST = CNT_W'(LOC_W - 1);
  localparam logic [CNT_W-1:0] RAW_LAST = CNT_W'(BLK_W - 1);

  sbd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             take;
  logic             st_en;

  assign in_ready  = (st_q != ST_OUT);
  assign blk_valid = (st_q == ST_OUT);
  assign take      = in_valid && in_ready;
  assign fld_shift = take && ((st_q == ST_CNT) || (st_q == ST_LOC));
  assign idx       = cnt_q[LOC_W-1:0];
  assign st_en     = take || (blk_valid && blk_ready);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    rem_d = rem_q;
    op    = OP_HOLD;
    unique case (st_q)
      ST_PFX: begin
        if (take) begin
          if (!in_bit) begin
            cnt_d = '0;
            if (cnt_q == '0) begin
              op   = OP_ZERO;
              st_d = ST_OUT;
            end else if (cnt_q == ONE) begin
              op   = OP_ONES;
              st_d = ST_OUT;
            end else begin
              op   = OP_CLR;
              st_d = ST_CNT;
            end
          end else if (cnt_q == TWO) begin
            cnt_d = '0;
            st_d  = ST_RAW;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_CNT: begin
        if (take) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            rem_d = fld_nx;
            st_d  = (fld_nx == '0) ? ST_OUT : ST_LOC;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_LOC: begin
        if (take) begin
          if (cnt_q == LOC_LAST) begin
            op    = OP_SET;
            cnt_d = '0;
            rem_d = rem_q - ONE;
            if (rem_q == ONE) st_d = ST_OUT;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_RAW: begin
        if (take) begin
          op = OP_RAW;
          if (cnt_q == RAW_LAST) begin
            cnt_d = '0;
            st_d  = ST_OUT;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      ST_OUT: begin
        if (blk_ready) st_d = ST_PFX;
      end
      default: st_d = ST_PFX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PFX;
      cnt_q <= '0;
      rem_q <= '0;
    end else if (st_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/sparse_blk_decomp.sv
module sparse_blk_decomp
  import sbd_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic [BLK_W-1:0] blk_data
);

  localparam int LOC_W = $clog2(BLK_W);
  localparam int CNT_W = $clog2(BLK_W + 1);

  logic [CNT_W-1:0] fld_nx;
  logic             fld_shift;
  logic [LOC_W-1:0] idx;
  sbd_op_e          op;

  sbd_fsm #(
    .BLK_W(BLK_W),
    .LOC_W(LOC_W),
    .CNT_W(CNT_W)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .blk_ready(blk_ready),
    .fld_nx   (fld_nx),
    .in_ready (in_ready),
    .blk_valid(blk_valid),
    .fld_shift(fld_shift),
    .op       (op),
    .idx      (idx)
  );

  sbd_field #(
    .FLD_W(CNT_W)
  ) i_field (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(fld_shift),
    .in_bit  (in_bit),
    .fld_nx  (fld_nx)
  );

  sbd_blk_reg #(
    .BLK_W(BLK_W),
    .LOC_W(LOC_W)
  ) i_blk (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .loc   (fld_nx[LOC_W-1:0]),
    .idx   (idx),
    .in_bit(in_bit),
    .blk_q (blk_data)
  );

endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
  parameter int BLK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic [BLK_W-1:0] blk_data
);

  // R9
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data)));

  // R9
  blk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready) |=> (!blk_valid && in_ready));

  // R8
  in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !in_ready);

  // R8
  done_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_valid) |-> $past(in_valid && in_ready));

endmodule

bind sparse_blk_decomp sbd_chk #(.BLK_W(BLK_W)) i_sbd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .blk_valid(blk_valid),
  .blk_ready(blk_ready),
  .blk_data (blk_data)
);

// File: tb/test_sparse_blk_decomp.sv
`timescale 1ns/1ps
module test_sparse_blk_decomp;

  localparam int K  = 8;
  localparam int LW = $clog2(K);
  localparam int CW = $clog2(K + 1);

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_bit;
  logic         in_ready;
  logic         blk_valid;
  logic         blk_ready;
  logic [K-1:0] blk_data;

  int checks   = 0;
  int failures = 0;
  int gap      = 0;
  bit stall_en = 0;
  int stall_cnt = 0;

  logic [K-1:0] exp_q[$];
  string        tag_q[$];

  sparse_blk_decomp #(.BLK_W(K)) i_sparse_blk_decomp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .in_ready (in_ready),
    .blk_valid(blk_valid),
    .blk_ready(blk_ready),
    .blk_data (blk_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: drives backpressure, compares presented blocks with the queue
  always @(negedge clk) begin
    if (!rst_n) begin
      blk_ready = 1'b1;
    end else begin
      stall_cnt++;
      blk_ready = stall_en ? (stall_cnt % 3 == 0) : 1'b1;
      if (blk_valid) begin
        // R8: no input accepted while a block waits
        check("R8 in_ready low while blk_valid", {31'd0, in_ready}, 32'd0);
        if (exp_q.size() == 0) begin
          check("R8 unexpected block", 32'd1, 32'd0);
        end else begin
          // R9: data held and correct every presented cycle
          check({tag_q[0], " / R9"}, {{(32-K){1'b0}}, blk_data}, {{(32-K){1'b0}}, exp_q[0]});
          if (blk_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_bit   = 1'b0;
  endtask

  task automatic send_field(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic blk_zero(input string tag);
    exp_q.push_back('0); tag_q.push_back(tag);
    send_bit(1'b0);
  endtask

  task automatic blk_ones(input string tag);
    exp_q.push_back('1); tag_q.push_back(tag);
    send_bit(1'b1); send_bit(1'b0);
  endtask

  task automatic blk_sparse(input string tag, input int n, input logic [31:0] locs);
    logic [K-1:0] e;
    e = '0;
    for (int i = 0; i < n; i++) e[locs[i*4 +: 4]] = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_field(n, CW);
    for (int i = 0; i < n; i++) send_field(int'(locs[i*4 +: 4]), LW);
  endtask

  task automatic blk_raw(input string tag, input logic [K-1:0] d);
    exp_q.push_back(d); tag_q.push_back(tag);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < K; i++) send_bit(d[i]);
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check("R9 queue drained", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_bit    = 1'b0;
    blk_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 blk_valid in reset", {31'd0, blk_valid}, 32'd0);
    check("R1 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R8: latency of a one-bit block
    exp_q.push_back('0); tag_q.push_back("R2 zero block");
    send_bit(1'b0);
    @(negedge clk);
    check("R8 blk_valid one cycle after last bit", {31'd0, blk_valid}, 32'd1);
    drain();

    blk_ones("R3 ones block");
    blk_zero("R2 zero after ones");
    blk_sparse("R4 single location 5", 1, 32'h5);
    blk_sparse("R4 locations 0,7,3", 3, 32'h370);
    blk_sparse("R5 count zero", 0, 32'h0);
    blk_ones("R5 prefix right after empty sparse");
    blk_sparse("R6 repeated location 2", 3, 32'h622);
    blk_sparse("R4 all eight locations", 8, 32'h76543210);
    blk_raw("R7 raw A5", 8'hA5);
    blk_raw("R7 raw 01 first bit", 8'h01);
    blk_raw("R7 raw 80 last bit", 8'h80);
    drain();

    // R10: idle gaps between input bits
    gap = 2;
    blk_raw("R10 raw 3C with gaps", 8'h3C);
    blk_sparse("R10 sparse with gaps", 2, 32'h41);
    blk_ones("R10 ones with gaps");
    gap = 0;
    drain();

    // R9: backpressure
    stall_en = 1'b1;
    blk_zero("R9 stalled zero");
    blk_raw("R9 stalled raw C3", 8'hC3);
    blk_sparse("R9 stalled sparse", 2, 32'h16);
    blk_ones("R9 stalled ones");
    drain();
    stall_en = 1'b0;

    // R1: reset in the middle of a raw block
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 blk_valid after mid-block reset", {31'd0, blk_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after mid-block reset", {31'd0, in_ready}, 32'd1);
    blk_ones("R1 prefix decoded after reset");
    blk_sparse("R1 sparse after reset", 1, 32'h7);
    drain();

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule